// File: doc/BRIEF.md
# SDR SDRAM Data Path with Mask Latency Alignment

This block sits between an SDR SDRAM controller and the memory's shared data and mask pins. The controller issues one command per cycle (idle, read, write, burst stop) together with a burst-length code. The block expands the command into consecutive data beats. On write beats it drives the data pins and the byte masks in the same cycle. On read beats it tracks each beat through a pipeline whose length follows the programmed CAS latency of 2 or 3. It captures the returning data and raises a valid flag.

The mask has two different latencies. A write mask acts in the cycle it is presented. A read mask must reach the pins two cycles before the data it blanks. The block re-times each per-beat read mask so that it lands in that cycle. It also reports which byte lanes of a returned beat were left undriven. The drive enable is held off while read data may be on the pins and for one idle cycle after, so a read followed by a write never drives against the memory.

Top module: `sdr_dq_path`

## Requirements
- R1: While rst_ni is low and after reset with idle commands, dq_oe_o, dq_o, dqm_o, rd_valid_o, rd_hiz_o and rd_data_o are all zero.
- R2: cmd_i encodes 2'b00 idle, 2'b01 read, 2'b10 write, 2'b11 burst stop. A read or write starts a burst of 1, 2, 4 or 8 beats for bl_i codes 0, 1, 2, 3. The first beat is in the command cycle and the rest follow in consecutive cycles.
- R3: In a write beat that is not blocked by R7, dq_oe_o is 1 and dq_o equals wr_data_i in the same cycle. In every write beat dqm_o equals wr_mask_i in the same cycle. dq_o is zero whenever dq_oe_o is 0, and dqm_o is zero when no mask is due.
- R4: cl3_i = 0 selects latency 2 and cl3_i = 1 selects latency 3. A read beat in cycle t gives rd_valid_o = 1 in cycle t+CL+1, with rd_data_o holding the dq_i value seen in cycle t+CL. rd_valid_o is 0 in all other cycles.
- R5: The rd_mask_i value presented with a read beat in cycle t appears on dqm_o in cycle t+CL-2. That is the same cycle for latency 2 and one cycle later for latency 3, so it always lands two cycles before the data. A write beat has priority on dqm_o.
- R6: With each valid read beat, rd_hiz_o gives that beat's mask, one bit per byte lane, with bit 0 covering dq bits 7:0. The rd_data_o bits of every flagged lane are zero.
- R7: dq_oe_o is 0 in cycles t+1 through t+CL+1 after any read beat in cycle t, even when a write beat falls there. Such a blocked write beat is dropped and not retried.
- R8: A burst stop in cycle s ends the current burst. No beat occurs in cycle s or later. Read beats issued before s still return valid data.
- R9: A read or write command during a running burst abandons the remaining beats and starts a new burst with the new direction and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | Command: idle, read, write, burst stop |
| bl_i | input | 2 | Burst length code, sampled with read or write |
| cl3_i | input | 1 | CAS latency select: 0 for 2, 1 for 3 |
| wr_data_i | input | DQ_W | Write data for the current beat |
| wr_mask_i | input | LANES | Write byte masks for the current beat |
| rd_mask_i | input | LANES | Read byte masks for the current read beat |
| dq_i | input | DQ_W | Data seen on the shared pins |
| dq_o | output | DQ_W | Data to drive on the shared pins |
| dq_oe_o | output | 1 | Pin drive enable |
| dqm_o | output | LANES | Mask pins |
| rd_data_o | output | DQ_W | Captured read data, masked lanes zeroed |
| rd_hiz_o | output | LANES | Lanes of the captured beat that were not driven |
| rd_valid_o | output | 1 | Captured read beat valid |

## Verification
If the burst counter is wrong, beats are added or lost at the pins in the cycle right after the command: dq_oe_o stays up too long, or a read comes back with too few valid pulses. If the latency pipeline is wrong, rd_valid_o moves by a cycle and the data no longer matches dq_i from the expected cycle. A wrong read mask re-timing puts dqm_o one cycle early or late. A wrong turnaround window shows dq_oe_o high one cycle before or after rd_valid_o. Each of these is visible within CL+1 cycles of the read beat involved.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_STOP = 2'b11
  } sdr_cmd_e;

  localparam int unsigned BURST_MAX = 8;
  localparam int unsigned CNT_W     = $clog2(BURST_MAX);
  localparam int unsigned CL_MAX    = 3;
  localparam int unsigned PIPE_D    = CL_MAX + 1;  // return window plus idle cycle

  function automatic logic [CNT_W:0] burst_beats(input logic [1:0] code);
    return (CNT_W+1)'(1) << code;
  endfunction
endpackage

// File: rtl/sdr_beat_gen.sv
module sdr_beat_gen
  import sdr_dp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic [1:0] bl_i,
  output logic       beat_o,
  output logic       beat_rd_o
);
  sdr_cmd_e         cmd;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             mode_rd_q, mode_rd_d;
  logic [CNT_W:0]   len_m1;

  assign cmd    = sdr_cmd_e'(cmd_i);
  assign len_m1 = burst_beats(bl_i) - 1'b1;

  always_comb begin
    beat_o    = 1'b0;
    beat_rd_o = mode_rd_q;
    remain_d  = remain_q;
    mode_rd_d = mode_rd_q;
    unique case (cmd)
      CMD_RD, CMD_WR: begin
        beat_o    = 1'b1;
        beat_rd_o = (cmd == CMD_RD);
        mode_rd_d = (cmd == CMD_RD);
        remain_d  = len_m1[CNT_W-1:0];
      end
      CMD_STOP: remain_d = '0;
      default: if (remain_q != '0) begin
        beat_o   = 1'b1;
        remain_d = remain_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q  <= '0;
      mode_rd_q <= 1'b0;
    end else begin
      remain_q  <= remain_d;
      mode_rd_q <= mode_rd_d;
    end
  end

  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_i) == CMD_STOP && cmd_i == CMD_NOP) |-> !beat_o); // R8

  AST_SINGLE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_i) inside {CMD_RD, CMD_WR} && $past(bl_i) == 2'd0 && cmd_i == CMD_NOP)
      |-> !beat_o); // R2
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe
  import sdr_dp_pkg::*;
#(
  parameter int unsigned DQ_W  = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_beat_i,
  input  logic [LANES-1:0] rd_mask_i,
  input  logic             cl3_i,
  input  logic [DQ_W-1:0]  dq_i,
  output logic             busy_o,
  output logic             dqm_vld_o,
  output logic [LANES-1:0] dqm_o,
  output logic             rd_valid_o,
  output logic [LANES-1:0] rd_hiz_o,
  output logic [DQ_W-1:0]  rd_data_o
);
  localparam int unsigned LW = DQ_W / LANES;

  logic [PIPE_D-1:0] v_q;             // v_q[k]: read beat k+1 cycles ago
  logic [LANES-1:0]  m_q [PIPE_D];
  logic [PIPE_D-1:0] win;
  logic              ret_v;
  logic [LANES-1:0]  ret_m;
  logic [DQ_W-1:0]   dq_m;
  logic              rd_valid_q;
  logic [LANES-1:0]  rd_hiz_q;
  logic [DQ_W-1:0]   rd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int k = 0; k < PIPE_D; k++) m_q[k] <= '0;
    end else begin
      v_q    <= {v_q[PIPE_D-2:0], rd_beat_i};
      m_q[0] <= rd_beat_i ? rd_mask_i : '0;
      for (int k = 1; k < PIPE_D; k++) m_q[k] <= m_q[k-1];
    end
  end

  assign win    = cl3_i ? {PIPE_D{1'b1}} : ({PIPE_D{1'b1}} >> 1);
  assign busy_o = |(v_q & win);

  // read mask must reach the pins two cycles before its data
  assign dqm_vld_o = cl3_i ? v_q[0] : rd_beat_i;
  assign dqm_o     = cl3_i ? m_q[0] : (rd_beat_i ? rd_mask_i : '0);

  assign ret_v = cl3_i ? v_q[2] : v_q[1];
  assign ret_m = cl3_i ? m_q[2] : m_q[1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dq_m[l*LW +: LW] = ret_m[l] ? '0 : dq_i[l*LW +: LW];

    AST_LANE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_q && !rd_hiz_q[l]) |-> rd_data_q[l*LW +: LW] == $past(dq_i[l*LW +: LW])); // R4
    AST_LANE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_hiz_q[l] |-> (rd_valid_q && rd_data_q[l*LW +: LW] == '0)); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_hiz_q   <= '0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= ret_v;
      rd_hiz_q   <= ret_v ? ret_m : '0;
      rd_data_q  <= ret_v ? dq_m : '0;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_hiz_o   = rd_hiz_q;
  assign rd_data_o  = rd_data_q;

  AST_CL2_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cl3_i && !$past(cl3_i) && !$past(cl3_i, 2) && $past(v_q[0], 2)) |-> rd_valid_q); // R4
  AST_CL3_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl3_i && $past(cl3_i) && $past(cl3_i, 2) && $past(cl3_i, 3) && $past(v_q[0], 3))
      |-> rd_valid_q); // R4
endmodule

// File: rtl/sdr_dq_path.sv
module sdr_dq_path
  import sdr_dp_pkg::*;
#(
  parameter int unsigned DQ_W = 16,
  localparam int unsigned LANES = (DQ_W > 8) ? DQ_W / 8 : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cmd_i,
  input  logic [1:0]       bl_i,
  input  logic             cl3_i,
  input  logic [DQ_W-1:0]  wr_data_i,
  input  logic [LANES-1:0] wr_mask_i,
  input  logic [LANES-1:0] rd_mask_i,
  input  logic [DQ_W-1:0]  dq_i,
  output logic [DQ_W-1:0]  dq_o,
  output logic             dq_oe_o,
  output logic [LANES-1:0] dqm_o,
  output logic [DQ_W-1:0]  rd_data_o,
  output logic [LANES-1:0] rd_hiz_o,
  output logic             rd_valid_o
);
  logic             beat, beat_rd, wr_beat, rd_beat;
  logic             busy, dqm_rd_vld;
  logic [LANES-1:0] dqm_rd;

  sdr_beat_gen u_beat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .bl_i      (bl_i),
    .beat_o    (beat),
    .beat_rd_o (beat_rd)
  );

  assign wr_beat = beat & ~beat_rd;
  assign rd_beat = beat & beat_rd;

  sdr_rd_pipe #(.DQ_W(DQ_W), .LANES(LANES)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_beat_i  (rd_beat),
    .rd_mask_i  (rd_mask_i),
    .cl3_i      (cl3_i),
    .dq_i       (dq_i),
    .busy_o     (busy),
    .dqm_vld_o  (dqm_rd_vld),
    .dqm_o      (dqm_rd),
    .rd_valid_o (rd_valid_o),
    .rd_hiz_o   (rd_hiz_o),
    .rd_data_o  (rd_data_o)
  );

  // write mask latency 0: mask leaves with its data
  assign dq_oe_o = wr_beat & ~busy;
  assign dq_o    = dq_oe_o ? wr_data_i : '0;
  assign dqm_o   = wr_beat ? wr_mask_i : (dqm_rd_vld ? dqm_rd : '0);

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!dq_oe_o && !$past(dq_oe_o))); // R7
  AST_WR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqm_o == wr_mask_i)); // R3
  AST_DQM_CL3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl3_i && $past(cl3_i) && $past(rst_ni) && $past(rd_beat) && !wr_beat)
      |-> (dqm_o == $past(rd_mask_i))); // R5
endmodule

// File: tb/sdr_dq_path_test.sv
`timescale 1ns/1ps
module sdr_dq_path_test;
  localparam int DQ_W  = 16;
  localparam int LANES = 2;
  localparam int LW    = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       cmd_i = 2'b00;
  logic [1:0]       bl_i = 2'b00;
  logic             cl3_i = 1'b0;
  logic [DQ_W-1:0]  wr_data_i = '0;
  logic [LANES-1:0] wr_mask_i = '0;
  logic [LANES-1:0] rd_mask_i = '0;
  logic [DQ_W-1:0]  dq_i = '0;
  logic [DQ_W-1:0]  dq_o;
  logic             dq_oe_o;
  logic [LANES-1:0] dqm_o;
  logic [DQ_W-1:0]  rd_data_o;
  logic [LANES-1:0] rd_hiz_o;
  logic             rd_valid_o;

  always #4 clk = ~clk;  // 125 MHz

  sdr_dq_path #(.DQ_W(DQ_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .bl_i(bl_i), .cl3_i(cl3_i),
    .wr_data_i(wr_data_i), .wr_mask_i(wr_mask_i), .rd_mask_i(rd_mask_i), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dqm_o(dqm_o), .rd_data_o(rd_data_o),
    .rd_hiz_o(rd_hiz_o), .rd_valid_o(rd_valid_o)
  );

  int    n_vec = 0;
  int    n_err = 0;
  bit    done = 0;
  string ph = "R2";

  // reference model state
  int               n = 8;
  int               m_rem = 0;
  bit               m_rd = 0;
  bit               h_rd [8];
  logic [LANES-1:0] h_mask [8];
  logic [DQ_W-1:0]  h_dq [8];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (phase %s) cycle %0d: actual %0h expected %0h", tag, ph, n, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] lane_zero(logic [DQ_W-1:0] d, logic [LANES-1:0] m);
    logic [DQ_W-1:0] r = d;
    for (int l = 0; l < LANES; l++) if (m[l]) r[l*LW +: LW] = '0;
    return r;
  endfunction

  function automatic int beats_of(logic [1:0] code);
    return 1 << code;
  endfunction

  task automatic step(logic [1:0] cmd, logic [1:0] bl);
    bit               beat, rd, busy, ev;
    int               cl;
    logic [LANES-1:0] edqm, ehiz;
    logic [DQ_W-1:0]  edq, edata;
    @(posedge clk); #1;
    cmd_i = cmd; bl_i = bl;
    wr_data_i = DQ_W'($urandom); wr_mask_i = LANES'($urandom);
    rd_mask_i = LANES'($urandom); dq_i = DQ_W'($urandom);
    cl = cl3_i ? 3 : 2;
    beat = 0; rd = m_rd;
    if (cmd == 2'b01 || cmd == 2'b10) begin beat = 1; rd = (cmd == 2'b01); end
    else if (cmd == 2'b00 && m_rem > 0) beat = 1;
    busy = 0;
    for (int k = 1; k <= cl + 1; k++) busy |= h_rd[(n-k) & 7];
    edq = (beat && !rd && !busy) ? wr_data_i : '0;
    if (beat && !rd) edqm = wr_mask_i;
    else if (cl == 2) edqm = (beat && rd) ? rd_mask_i : '0;
    else edqm = h_rd[(n-1) & 7] ? h_mask[(n-1) & 7] : '0;
    ev    = h_rd[(n-cl-1) & 7];
    ehiz  = ev ? h_mask[(n-cl-1) & 7] : '0;
    edata = ev ? lane_zero(h_dq[(n-1) & 7], ehiz) : '0;
    @(negedge clk);
    chk(busy ? "R7" : "R3", dq_oe_o, beat && !rd && !busy);
    chk("R3", dq_o, edq);
    chk((beat && !rd) ? "R3" : "R5", dqm_o, edqm);
    chk("R4", rd_valid_o, ev);
    chk("R4", rd_data_o, edata);
    chk("R6", rd_hiz_o, ehiz);
    h_rd[n & 7]   = beat && rd;
    h_mask[n & 7] = (beat && rd) ? rd_mask_i : '0;
    h_dq[n & 7]   = dq_i;
    if (cmd == 2'b01 || cmd == 2'b10) begin m_rd = rd; m_rem = beats_of(bl) - 1; end
    else if (cmd == 2'b11) m_rem = 0;
    else if (m_rem > 0) m_rem--;
    n++;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(2'b00, 2'b00);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (phase %s): actual hung expected done", ph);
    summary();
  end

  initial begin
    void'($urandom(32'h5d2a71));
    for (int i = 0; i < 8; i++) begin h_rd[i] = 0; h_mask[i] = '0; h_dq[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    ph = "R1";
    chk("R1", dq_oe_o, 0); chk("R1", dqm_o, 0); chk("R1", rd_valid_o, 0);
    chk("R1", rd_data_o, 0);
    rst_ni = 1'b1;
    idle(2);

    ph = "R2";
    for (int c = 0; c < 2; c++) begin
      cl3_i = c[0];
      for (int b = 0; b < 4; b++) begin
        step(2'b10, 2'(b)); idle(beats_of(2'(b)) + 1);
        step(2'b01, 2'(b)); idle(beats_of(2'(b)) + 5);
      end
    end

    ph = "R8";
    for (int c = 0; c < 2; c++) begin
      cl3_i = c[0];
      step(2'b01, 2'd3); idle(2); step(2'b11, 2'd0); idle(6);
      step(2'b10, 2'd3); idle(2); step(2'b11, 2'd0); idle(3);
      step(2'b01, 2'd1); step(2'b11, 2'd0); idle(6);
    end

    ph = "R9";
    for (int c = 0; c < 2; c++) begin
      cl3_i = c[0];
      step(2'b10, 2'd3); idle(1); step(2'b01, 2'd1); idle(6);
      step(2'b01, 2'd3); idle(1); step(2'b01, 2'd0); idle(6);
    end

    ph = "R7";
    for (int c = 0; c < 2; c++) begin
      cl3_i = c[0];
      for (int gap = 0; gap < 6; gap++) begin
        step(2'b01, 2'd0); idle(gap); step(2'b10, 2'd2); idle(8);
      end
    end

    ph = "R5";
    for (int blk = 0; blk < 12; blk++) begin
      cl3_i = 1'($urandom);
      for (int i = 0; i < 200; i++) begin
        int r = $urandom_range(0, 9);
        logic [1:0] cmd = (r < 5) ? 2'b00 : (r < 7) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
        step(cmd, 2'($urandom));
      end
      step(2'b11, 2'd0);
      idle(6);
    end

    summary();
  end
endmodule